// File: doc/BRIEF.md
# Flag-Setting 16x16 Multiplier

This unit sits in a CPU execution stage and performs the word multiply. It takes a 16-bit source operand and the 32-bit value of a data register, of which it uses only the lower half. It forms a 32-bit product and returns it together with the four condition flags, ready to replace the whole register. A mode input selects unsigned or two's-complement signed operation. One datapath serves both modes.

An operation begins with a single-cycle `start` while the unit is idle. The unit latches the operands and runs an iterative shift-add loop that retires one multiplier bit per clock. It then raises `done` for one cycle. At that point `result`, the flags and a fixed nominal cycle figure of 38 are valid. These outputs hold until the next completion. For signed operation the loop multiplies operand magnitudes, and the product is negated at the end when the operand signs differ.

Top module: `mul16_flags_unit`

## Requirements
- R1: Bits 31..16 of `dst_reg` have no effect on any output; only bits 15..0 of `dst_reg` and all 16 bits of `src_op` enter the product.
- R2: With `is_signed` = 0 both operands are zero-extended and `result` equals their unsigned 32-bit product (e.g. 0xFFFF x 0xFFFF = 0xFFFE0001).
- R3: With `is_signed` = 1 both operands are sign-extended and `result` equals their two's-complement 32-bit product (e.g. 0x8000 x 0x8000 = 0x40000000, 0x8000 x 0x0001 = 0xFFFF8000).
- R4: `result` holds the full 32-bit product from the completion cycle and stays unchanged until the next completion.
- R5: `flag_n` equals bit 31 of the product, and `flag_z` is 1 exactly when all 32 bits of the product are zero.
- R6: `flag_v` and `flag_c` are 0 after every completed multiply.
- R7: `cycles` reads 38 after every completion, in either mode.
- R8: `busy` is 1 from the first cycle after a start is accepted until `done`. `done` is a one-cycle pulse that is first visible 17 clock edges after the accepting edge (operand width plus one).
- R9: A `start` seen while `busy` is 1 is ignored, and operand or mode changes after acceptance do not alter the result. No extra `done` pulse follows when `start` stays low.
- R10: A synchronous active-high `rst` clears `result`, all flags, `cycles`, `done` and `busy` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply; accepted only when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| src_op | input | 16 | Source operand |
| dst_reg | input | 32 | Destination register value; lower half is the second operand |
| result | output | 32 | 32-bit product, the new register value |
| flag_n | output | 1 | Negative flag, bit 31 of the product |
| flag_z | output | 1 | Zero flag, product equals zero |
| flag_v | output | 1 | Overflow flag, always cleared |
| flag_c | output | 1 | Carry flag, always cleared |
| cycles | output | 8 | Nominal execution time reported at completion (38) |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The stimulus pairs the same 16-bit patterns under both modes. A pair such as 0xFFFF x 0xFFFF gives 0xFFFE0001 unsigned and 1 signed, which separates a missing or wrong sign extension from a correct one. The most-negative operand (0x8000) squared and times one checks magnitude handling and the final negation. Zero operands and a -1 x 1 product check the Z and N flags at their extremes. Random upper halves on `dst_reg`, operand changes and start pulses while busy show whether anything outside the latched low operands leaks into the result. Random seeded operand pairs in both modes cover the carry chain of the shift-add loop.

// File: rtl/mul16_pkg.sv
package mul16_pkg;

    localparam int OP_W           = 16;
    localparam int RES_W          = 2 * OP_W;
    localparam int CYC_W          = 8;
    localparam int NOMINAL_CYCLES = 38;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } mul_state_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/mul16_operand_prep.sv
module mul16_operand_prep #(
    parameter int W = mul16_pkg::OP_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sgn,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg
);

    logic a_neg;
    logic b_neg;

    assign a_neg = sgn & op_a[W-1];
    assign b_neg = sgn & op_b[W-1];

    // magnitude of the most negative value is 2**(W-1), which still fits W bits
    assign mag_a = a_neg ? (~op_a + 1'b1) : op_a;
    assign mag_b = b_neg ? (~op_b + 1'b1) : op_b;
    assign neg   = a_neg ^ b_neg;

endmodule

// File: rtl/mul16_shift_add.sv
module mul16_shift_add #(
    parameter int W = mul16_pkg::OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    input  logic           neg_in,
    output logic           running,
    output logic           last,
    output logic [2*W-1:0] product,
    output logic           neg_out
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam int AW = 2 * W + 1;

    logic [AW-1:0] acc;
    logic [W-1:0]  mcand;
    logic [CW-1:0] count;
    logic          run_q;
    logic          neg_q;
    logic [W:0]    upper_sum;
    logic          unused_acc_msb;

    always_comb begin
        upper_sum = acc[AW-1:W];
        if (acc[0]) begin
            upper_sum = acc[AW-1:W] + {1'b0, mcand};
        end
    end

    assign last           = run_q && (count == CW'(W - 1));
    assign running        = run_q;
    assign product        = acc[2*W-1:0];
    assign neg_out        = neg_q;
    assign unused_acc_msb = acc[AW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            mcand <= '0;
            count <= '0;
            run_q <= 1'b0;
            neg_q <= 1'b0;
        end else if (load) begin
            acc   <= {{(W+1){1'b0}}, mplier_in};
            mcand <= mcand_in;
            neg_q <= neg_in;
            count <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            acc   <= {1'b0, upper_sum, acc[W-1:1]};
            count <= count + 1'b1;
            if (last) begin
                run_q <= 1'b0;
            end
        end
    end

    // R8: each running step advances the bit counter by exactly one
    assert_step_count_R8: assert property (@(posedge clk) disable iff (rst)
        (run_q && !last && !load) |=> (run_q && count == $past(count) + 1'b1));

    // R9: the controller never reloads operands mid-operation
    assert_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> !run_q);

endmodule

// File: rtl/mul16_flags_unit.sv
module mul16_flags_unit #(
    parameter int W       = mul16_pkg::OP_W,
    parameter int CYC_W   = mul16_pkg::CYC_W,
    parameter int NOMINAL = mul16_pkg::NOMINAL_CYCLES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_signed,
    input  logic [W-1:0]     src_op,
    input  logic [2*W-1:0]   dst_reg,
    output logic [2*W-1:0]   result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    output logic [CYC_W-1:0] cycles,
    output logic             done,
    output logic             busy
);
    import mul16_pkg::*;

    localparam int RW    = 2 * W;
    localparam int LAT_W = $clog2(W + 3) + 1;

    mul_state_t     state;
    ccr_t           ccr_q;
    ccr_t           ccr_next;
    logic           accept;
    logic [W-1:0]   mag_a;
    logic [W-1:0]   mag_b;
    logic           prep_neg;
    logic           eng_running;
    logic           eng_last;
    logic [RW-1:0]  eng_product;
    logic           eng_neg;
    logic [RW-1:0]  final_p;
    logic           unused_upper;

    // the upper half of the destination register never reaches the datapath
    assign unused_upper = ^dst_reg[RW-1:W];

    assign accept = start && (state == ST_IDLE);

    mul16_operand_prep #(.W(W)) u_prep (
        .op_a  (src_op),
        .op_b  (dst_reg[W-1:0]),
        .sgn   (is_signed),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .neg   (prep_neg)
    );

    mul16_shift_add #(.W(W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .neg_in    (prep_neg),
        .running   (eng_running),
        .last      (eng_last),
        .product   (eng_product),
        .neg_out   (eng_neg)
    );

    assign final_p    = eng_neg ? (~eng_product + 1'b1) : eng_product;
    assign ccr_next.n = final_p[RW-1];
    assign ccr_next.z = (final_p == '0);
    assign ccr_next.v = 1'b0;
    assign ccr_next.c = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            result <= '0;
            ccr_q  <= '0;
            cycles <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) state <= ST_RUN;
                ST_RUN:  if (eng_last) state <= ST_FIN;
                ST_FIN: begin
                    result <= final_p;
                    ccr_q  <= ccr_next;
                    cycles <= CYC_W'(NOMINAL);
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_v = ccr_q.v;
    assign flag_c = ccr_q.c;

    // latency counter used only by the checks below
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
        end else if (accept) begin
            lat_cnt <= LAT_W'(1);
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R8: completion arrives W+1 edges after acceptance (counter includes the accept edge and the edge that raises done)
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == LAT_W'(W + 2)));

    // R8: done never lasts two cycles
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: flags agree with the registered result
    assert_flag_n_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_n == result[RW-1]));
    assert_flag_z_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_z == (result == '0)));

    // R4: result is held while the loop is stepping
    assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> $stable(result));

    // R8: the engine steps only while the controller is in its run state
    assert_engine_sync_R8: assert property (@(posedge clk) disable iff (rst)
        eng_running |-> (state == ST_RUN));

endmodule

// File: tb/sim_mul16_flags_unit.sv
module sim_mul16_flags_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        is_signed;
    logic [15:0] src_op;
    logic [31:0] dst_reg;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic [7:0]  cycles;
    logic        done;
    logic        busy;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    mul16_flags_unit u0 (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .src_op(src_op), .dst_reg(dst_reg), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .cycles(cycles), .done(done), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mul(input logic sgn, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] ea, eb;
        ea = sgn ? {{16{a[15]}}, a} : {16'h0, a};
        eb = sgn ? {{16{b[15]}}, b} : {16'h0, b};
        return ea * eb;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // R1-related stimulus, R2/R3 products, R4..R9 timing and flags
    task automatic run_op(input logic sgn, input logic [15:0] s, input logic [31:0] d, input string req);
        logic [31:0] exp;
        int n;
        exp = ref_mul(sgn, s, d[15:0]);
        @(negedge clk);
        start = 1'b1; is_signed = sgn; src_op = s; dst_reg = d;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after accept", {31'b0, busy}, 32'd1);
        // R9: scramble inputs while busy
        src_op = 16'($urandom); dst_reg = $urandom; is_signed = ~sgn;
        n = 0;
        while (!done && n < 60) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            start = (n == 5);
        end
        start = 1'b0;
        chk("R8 latency", n, 32'd17);
        chk(req, result, exp);
        chk("R5 flag_n", {31'b0, flag_n}, {31'b0, exp[31]});
        chk("R5 flag_z", {31'b0, flag_z}, {31'b0, exp == 32'h0});
        chk("R6 flag_v flag_c", {30'b0, flag_v, flag_c}, 32'd0);
        chk("R7 cycles", {24'b0, cycles}, 32'd38);
        @(negedge clk);
        chk("R8 done pulse ends", {31'b0, done}, 32'd0);
        chk("R8 busy cleared", {31'b0, busy}, 32'd0);
        chk("R4 result held", result, exp);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1; start = 1'b0; is_signed = 1'b0; src_op = '0; dst_reg = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset result", result, 32'h0);
        chk("R10 reset flags", {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'h0);
        chk("R10 reset cycles", {24'b0, cycles}, 32'h0);
        chk("R10 reset done busy", {30'b0, done, busy}, 32'h0);
        rst = 1'b0;

        run_op(1'b0, 16'hFFFF, 32'h0000FFFF, "R2 max unsigned");
        run_op(1'b1, 16'hFFFF, 32'h0000FFFF, "R3 minus one squared");
        run_op(1'b1, 16'h8000, 32'h00008000, "R3 most negative squared");
        run_op(1'b1, 16'h8000, 32'h00000001, "R3 most negative times one");
        run_op(1'b0, 16'h8000, 32'h00000001, "R2 high bit unsigned");
        run_op(1'b1, 16'hFFFF, 32'h00000001, "R3 negative result");
        run_op(1'b0, 16'h0000, 32'h1234ABCD, "R5 zero product");
        run_op(1'b1, 16'h1234, 32'hFFFF0000, "R1 zero low half");
        run_op(1'b0, 16'h0003, 32'hDEAD0005, "R1 upper half ignored");
        run_op(1'b1, 16'h7FFF, 32'h55558001, "R1 signed upper ignored");

        for (int i = 0; i < 60; i++) begin
            logic sg;
            sg = 1'($urandom);
            run_op(sg, 16'($urandom), $urandom, sg ? "R3 random" : "R2 random");
        end

        // R9: no further done with start low
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R9 no spurious done", extra, 32'd0);
        end

        // R10: reset after a completion clears the held result
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 result cleared", result, 32'h0);
        chk("R10 cycles cleared", {24'b0, cycles}, 32'h0);

        finish_run();
    end

endmodule